// File: doc/BRIEF.md
# Serial Port Register Interface

This block is the processor-facing register file of a small memory-mapped serial port. It holds a one-byte receive holding register, a one-byte transmit holding register, a control register and a status word. It also keeps the flag handshake between the processor and the serial shift logic. The shift logic itself is outside the block and appears here only as strobes: a receive strobe that delivers a finished byte, and a take strobe that removes the pending transmit byte.

The bus decodes two locations. Location 0 is the data port: a read returns the received byte and a write loads the byte to send. Location 1 carries both control and status, and the access direction picks which one. A write there updates control and a read there returns status. Control sets the request-to-send output, enables the receive-full and transmit-empty interrupts, and picks a rate divisor for a baud tick generator. The interrupt request output is built from the enables and the flags.

Top module: `uart_csr`

## Requirements
- R1: After reset the status word reads 0x40, and `rts`, `irq` and `tx_valid` are 0 with `tx_byte` equal to 0.
- R2: A write to location 1 updates control from write-data bits [3:0] (speed), bit 4 (receive interrupt enable), bit 5 (transmit interrupt enable) and bit 6 (request-to-send). Bits 7 and above are ignored. A read of location 1 always returns status and never control.
- R3: The status word has bit 0 = overrun, bit 5 = receive holding register full and bit 6 = transmit holding register empty. All other bits read 0.
- R4: A receive strobe stores `rx_byte` and sets receive-full. A read of location 0 returns the stored byte in its low 8 bits, with 0 above, and clears receive-full.
- R5: A receive strobe while receive-full is set, with no read of location 0 in the same cycle, sets overrun. A status read clears overrun unless a new overrun occurs in that same cycle. A data read in the same cycle as a strobe returns the old byte, leaves receive-full set with the new byte, and raises no overrun.
- R6: A write to location 0 presents the byte on `tx_byte`, raises `tx_valid` and clears transmit-empty. `tx_take` with a byte pending sets transmit-empty. `tx_take` with nothing pending has no effect. A write and a take in the same cycle leave the new byte pending.
- R7: `irq` is 1 exactly when (receive interrupt enable and receive-full) or (transmit interrupt enable and transmit-empty).
- R8: `rts` equals the request-to-send control bit.
- R9: `baud_tick` pulses for one cycle every BASE_DIV*(speed+1) clock cycles, so speed 1 gives half the highest rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data port, 1 = control/status |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data (combinational) |
| rx_strobe | input | 1 | Shift logic delivers a received byte |
| rx_byte | input | DATA_W | Received byte |
| tx_take | input | 1 | Shift logic takes the pending byte |
| tx_byte | output | DATA_W | Byte to transmit |
| tx_valid | output | 1 | A transmit byte is pending |
| rts | output | 1 | Request-to-send to the remote end |
| baud_tick | output | 1 | Rate tick for the shift logic |
| irq | output | 1 | Interrupt request |

## Verification
A wrong flag shows up in the status word on the next read and in `irq` in the cycle after the event that corrupts it. A stuck overrun shows as bit 0 that survives a status read. A lost byte shows as a wrong value on the data read. The same-cycle collisions, strobe against data read, strobe against status read and write against take, each move a flag one way or the other. So each of them shows at the very next status read or pin sample. A wrong divisor shows as a wrong tick spacing within one period.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
    localparam int SPEED_W  = 4;
    localparam int CTL_RXIE = 4;
    localparam int CTL_TXIE = 5;
    localparam int CTL_RTS  = 6;
    localparam int STS_OVR  = 0;
    localparam int STS_RXF  = 5;
    localparam int STS_TXE  = 6;

    typedef struct packed {
        logic               rts;
        logic               tx_ie;
        logic               rx_ie;
        logic [SPEED_W-1:0] speed;
    } ctrl_t;
endpackage

// File: rtl/uart_csr_rx.sv
module uart_csr_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_strobe,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rd_data,
    input  logic              rd_status,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              overrun
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              ovr;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_status) st_d.ovr  = 1'b0;
        if (rd_data)   st_d.full = 1'b0;
        if (rx_strobe) begin
            st_d.data = rx_byte;
            st_d.full = 1'b1;
            if (st_q.full && !rd_data) st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_data = st_q.data;
    assign rx_full = st_q.full;
    assign overrun = st_q.ovr;

    // R4
    rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> (rx_full && rx_data == $past(rx_byte)));
    // R5
    rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && rx_full && !rd_data) |=> overrun);
    // R4
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rx_strobe) |=> !rx_full);
endmodule

// File: rtl/uart_csr_tx.sv
module uart_csr_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_take,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_empty
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              empty;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tx_take && !st_q.empty) st_d.empty = 1'b1;
        if (wr_data) begin
            st_d.data  = wdata;
            st_d.empty = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data  <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_byte  = st_q.data;
    assign tx_empty = st_q.empty;

    // R6
    tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (!tx_empty && tx_byte == $past(wdata)));
    // R6
    tx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_take && !wr_data) |=> tx_empty);
endmodule

// File: rtl/uart_csr_baud.sv
module uart_csr_baud #(
    parameter int SPEED_W  = 4,
    parameter int BASE_DIV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SPEED_W-1:0] speed,
    output logic               baud_tick
);
    localparam int CW = SPEED_W + $clog2(BASE_DIV) + 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit     = (CW'(speed) + CW'(1)) * CW'(BASE_DIV) - CW'(1);
        baud_tick = (cnt_q >= limit);
        cnt_d     = baud_tick ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9
    baud_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick);
endmodule

// File: rtl/uart_csr.sv
module uart_csr
    import uart_csr_pkg::*;
#(
    parameter int BUS_W    = 32,
    parameter int DATA_W   = 8,
    parameter int BASE_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rx_strobe,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              tx_take,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_valid,
    output logic              rts,
    output logic              baud_tick,
    output logic              irq
);
    ctrl_t ctrl_d, ctrl_q;
    logic  rd_data, rd_status, wr_data, wr_ctrl;
    logic  rx_full, overrun, tx_empty;
    logic [DATA_W-1:0] rx_data;
    logic  unused_wbits;

    assign unused_wbits = ^bus_wdata;

    always_comb begin
        rd_data   = bus_sel && !bus_wr && !bus_addr;
        rd_status = bus_sel && !bus_wr &&  bus_addr;
        wr_data   = bus_sel &&  bus_wr && !bus_addr;
        wr_ctrl   = bus_sel &&  bus_wr &&  bus_addr;
        ctrl_d    = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d.speed = bus_wdata[SPEED_W-1:0];
            ctrl_d.rx_ie = bus_wdata[CTL_RXIE];
            ctrl_d.tx_ie = bus_wdata[CTL_TXIE];
            ctrl_d.rts   = bus_wdata[CTL_RTS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    uart_csr_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
        .rd_data(rd_data), .rd_status(rd_status), .rx_data(rx_data),
        .rx_full(rx_full), .overrun(overrun));

    uart_csr_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
        .wdata(bus_wdata[DATA_W-1:0]), .tx_take(tx_take),
        .tx_byte(tx_byte), .tx_empty(tx_empty));

    uart_csr_baud #(.SPEED_W(SPEED_W), .BASE_DIV(BASE_DIV)) u_baud (
        .clk(clk), .rst_n(rst_n), .speed(ctrl_q.speed), .baud_tick(baud_tick));

    always_comb begin
        bus_rdata = '0;
        if (bus_addr) begin
            bus_rdata[STS_OVR] = overrun;
            bus_rdata[STS_RXF] = rx_full;
            bus_rdata[STS_TXE] = tx_empty;
        end else begin
            bus_rdata[DATA_W-1:0] = rx_data;
        end
    end

    assign rts      = ctrl_q.rts;
    assign tx_valid = !tx_empty;
    assign irq      = (ctrl_q.rx_ie && rx_full) || (ctrl_q.tx_ie && tx_empty);

    // R8
    rts_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (rts == $past(bus_wdata[CTL_RTS])));
    // R7
    irq_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && ctrl_q.rx_ie && !wr_ctrl) |=> irq);
endmodule

// File: tb/uart_csr_tb.sv
module uart_csr_tb;
    localparam int BUS_W = 32;
    localparam int DATA_W = 8;
    localparam int BASE_DIV = 4;
    localparam int NV = 36;
    localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_RX = 3'd2,
                           OP_TK = 3'd3, OP_PIN = 3'd4;

    // {op, addr, data, expected, requirement number}
    // PIN expected = {irq, rts, tx_valid, tx_byte}
    localparam logic [71:0] VEC [NV] = '{
        {OP_RD,  1'b1, 32'h0,        32'h40,  4'd1}, // R1
        {OP_PIN, 1'b0, 32'h0,        32'h000, 4'd1}, // R1
        {OP_WR,  1'b1, 32'h41,       32'h0,   4'd2}, // R2
        {OP_PIN, 1'b0, 32'h0,        32'h200, 4'd8}, // R8
        {OP_RD,  1'b1, 32'h0,        32'h40,  4'd2}, // R2
        {OP_RX,  1'b0, 32'hA5,       32'h0,   4'd4}, // R4
        {OP_RD,  1'b1, 32'h0,        32'h60,  4'd3}, // R3
        {OP_RD,  1'b0, 32'h0,        32'hA5,  4'd4}, // R4
        {OP_RD,  1'b1, 32'h0,        32'h40,  4'd4}, // R4
        {OP_RX,  1'b0, 32'h11,       32'h0,   4'd5}, // R5
        {OP_RX,  1'b0, 32'h22,       32'h0,   4'd5}, // R5
        {OP_RD,  1'b1, 32'h0,        32'h61,  4'd5}, // R5
        {OP_RD,  1'b1, 32'h0,        32'h60,  4'd5}, // R5
        {OP_RD,  1'b0, 32'h0,        32'h22,  4'd5}, // R5
        {OP_RD,  1'b1, 32'h0,        32'h40,  4'd3}, // R3
        {OP_WR,  1'b0, 32'h5A,       32'h0,   4'd6}, // R6
        {OP_RD,  1'b1, 32'h0,        32'h00,  4'd3}, // R3
        {OP_PIN, 1'b0, 32'h0,        32'h35A, 4'd6}, // R6
        {OP_TK,  1'b0, 32'h0,        32'h0,   4'd6}, // R6
        {OP_RD,  1'b1, 32'h0,        32'h40,  4'd6}, // R6
        {OP_TK,  1'b0, 32'h0,        32'h0,   4'd6}, // R6
        {OP_PIN, 1'b0, 32'h0,        32'h25A, 4'd6}, // R6
        {OP_WR,  1'b1, 32'h20,       32'h0,   4'd7}, // R7
        {OP_PIN, 1'b0, 32'h0,        32'h45A, 4'd7}, // R7
        {OP_WR,  1'b0, 32'h33,       32'h0,   4'd7}, // R7
        {OP_PIN, 1'b0, 32'h0,        32'h133, 4'd7}, // R7
        {OP_WR,  1'b1, 32'h10,       32'h0,   4'd7}, // R7
        {OP_PIN, 1'b0, 32'h0,        32'h133, 4'd7}, // R7
        {OP_RX,  1'b0, 32'h77,       32'h0,   4'd7}, // R7
        {OP_PIN, 1'b0, 32'h0,        32'h533, 4'd7}, // R7
        {OP_RD,  1'b0, 32'h0,        32'h77,  4'd4}, // R4
        {OP_PIN, 1'b0, 32'h0,        32'h133, 4'd7}, // R7
        {OP_WR,  1'b1, 32'hFFFFFF80, 32'h0,   4'd2}, // R2
        {OP_PIN, 1'b0, 32'h0,        32'h133, 4'd2}, // R2
        {OP_WR,  1'b1, 32'h7F,       32'h0,   4'd2}, // R2
        {OP_PIN, 1'b0, 32'h0,        32'h333, 4'd8}  // R8
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [BUS_W-1:0] bus_wdata = '0;
    logic [BUS_W-1:0] bus_rdata;
    logic rx_strobe = 1'b0;
    logic [DATA_W-1:0] rx_byte = '0;
    logic tx_take = 1'b0;
    logic [DATA_W-1:0] tx_byte;
    logic tx_valid, rts, baud_tick, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_csr #(.BUS_W(BUS_W), .DATA_W(DATA_W), .BASE_DIV(BASE_DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_strobe(rx_strobe), .rx_byte(rx_byte), .tx_take(tx_take),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .rts(rts),
        .baud_tick(baud_tick), .irq(irq));

    function automatic logic [31:0] pins();
        return {21'd0, irq, rts, tx_valid, tx_byte};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        bus_sel = 1'b0; bus_wr = 1'b0; rx_strobe = 1'b0; tx_take = 1'b0;
    endtask

    task automatic run_op(input logic [2:0] op, input logic a, input logic [31:0] d,
                          input logic [31:0] exp, input int req);
        string tag;
        tag = $sformatf("vector R%0d", req);
        @(negedge clk);
        bus_addr = a;
        case (op)
            OP_WR: begin bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d; end
            OP_RD: begin bus_sel = 1'b1; bus_wr = 1'b0; end
            OP_RX: begin rx_strobe = 1'b1; rx_byte = d[DATA_W-1:0]; end
            OP_TK: tx_take = 1'b1;
            default: ;
        endcase
        #1;
        if (op == OP_RD)  check(tag, bus_rdata, exp);
        if (op == OP_PIN) check(tag, pins(), exp);
        @(posedge clk);
        #1 idle();
    endtask

    task automatic measure(input logic [3:0] spd, input int exp_period);
        int n;
        run_op(OP_WR, 1'b1, {28'd0, spd}, 32'h0, 9);
        n = 0;
        @(negedge clk);
        for (int i = 0; i < 200 && !baud_tick; i++) @(negedge clk);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            n++;
            if (baud_tick) break;
        end
        check($sformatf("R9 tick period speed %0d", spd), n, exp_period);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < NV; i++)
            run_op(VEC[i][71:69], VEC[i][68], VEC[i][67:36], VEC[i][35:4], int'(VEC[i][3:0]));

        // R5: data read and receive strobe in the same cycle
        run_op(OP_WR, 1'b1, 32'h00, 32'h0, 2);
        run_op(OP_RX, 1'b0, 32'h10, 32'h0, 5);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 1'b0;
        rx_strobe = 1'b1; rx_byte = 8'h20;
        #1 check("R5 collision read returns old byte", bus_rdata, 32'h10);
        @(posedge clk); #1 idle();
        run_op(OP_RD, 1'b1, 32'h0, 32'h20, 5); // R5 full, no overrun
        run_op(OP_RD, 1'b0, 32'h0, 32'h20, 5); // R5 new byte kept

        // R5: status read coinciding with a new overrun
        run_op(OP_RX, 1'b0, 32'h01, 32'h0, 5);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 1'b1;
        rx_strobe = 1'b1; rx_byte = 8'h02;
        #1 check("R5 status before overrun", bus_rdata, 32'h20);
        @(posedge clk); #1 idle();
        run_op(OP_RD, 1'b1, 32'h0, 32'h21, 5); // R5 overrun survives
        run_op(OP_RD, 1'b1, 32'h0, 32'h20, 5); // R5 cleared
        run_op(OP_RD, 1'b0, 32'h0, 32'h02, 5);

        // R6: write and take in the same cycle
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 32'h99;
        tx_take = 1'b1;
        @(posedge clk); #1 idle();
        @(negedge clk);
        check("R6 write beats take", pins(), 32'h199);

        // R9: tick spacing
        measure(4'd0, BASE_DIV);
        measure(4'd1, 2 * BASE_DIV);
        measure(4'd3, 4 * BASE_DIV);

        // R1: reset during operation
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        run_op(OP_RD, 1'b1, 32'h0, 32'h40, 1); // R1
        run_op(OP_PIN, 1'b0, 32'h0, 32'h000, 1); // R1

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule